// File: doc/BRIEF.md
# Fill-Level Driven Rate-Matching NCO

This block turns an irregular write strobe into an even read strobe, so that words pass through a small buffer with a fixed delay in time. Everything runs on one system clock. Writes and reads are single-cycle enables on that clock, not separate clocks. Incoming words enter a synchronous FIFO whenever the gapped input enable is high.

A phase accumulator adds the live FIFO occupancy on every clock. When the sum reaches a modulus, the accumulator subtracts the modulus and keeps the remainder, and the next cycle carries a one-cycle output enable. That enable pops the head word. The loop is purely proportional: a fuller buffer reads out faster and an emptier one reads out more slowly. The read rate therefore settles on the average write rate, with a standing occupancy of about the write rate times the modulus. Because that occupancy grows with the rate, the delay through the buffer stays the same in time. The modulus sets the loop gain and is captured while reset is held.

Top module: `fill_rate_nco`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_en` is 0, `fill` is 0, `overflow` and `underflow` are 0, and the accumulator is cleared.
- R2: On each clock the accumulator adds `fill`. When the sum is at least the modulus M, the accumulator keeps sum minus M and `out_en` is high for exactly the next cycle. After reset with one stored word, the first `out_en` is seen exactly M clock edges after the edge that stored the word.
- R3: The modulus is captured from `cfg_modulus` only while `rst_n` is low. A value of 0 selects 2^ACC_W-1 (4095 by default). A value of DEPTH or less is raised to DEPTH+1 (17 by default). Any other value is used as given.
- R4: In a cycle with `out_en` high and a non-empty FIFO, `out_data` shows the oldest stored word and that word is removed at the clock edge. Words leave in the order they arrived.
- R5: A push while the FIFO holds DEPTH words and no pop happens in the same cycle is dropped. `fill` stays at DEPTH and `overflow` is set and stays set until reset.
- R6: A push in the same cycle as a valid pop is accepted and leaves `fill` unchanged.
- R7: While `fill` is 0 the accumulator holds its value and `out_en` stays low.
- R8: `out_en` never occurs with an empty FIFO, so `underflow` (set by a pop when empty) stays 0 for any input pattern.
- R9: Over a long gapped input with no dropped words, accepted pushes minus pops equals `fill`. The settled `fill` is close to the input rate times M, which is higher for a faster input rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_modulus | input | ACC_W | Accumulator modulus, captured during reset |
| in_en | input | 1 | Gapped write enable |
| in_data | input | DATA_W | Word to store |
| out_en | output | 1 | Regenerated read enable, one cycle per wrap |
| out_data | output | DATA_W | Oldest stored word |
| fill | output | ADDR_W+1 | Current FIFO occupancy |
| overflow | output | 1 | Sticky: a write was dropped |
| underflow | output | 1 | Sticky: a read hit an empty FIFO |

## Verification
A write and a regenerated read can land on the same clock edge, including when the buffer is full. One test stores a single word and waits for the wrap. It then raises `in_en` in exactly the cycle where `out_en` is high, and it judges the result by an unchanged `fill` and by the new word coming out on the next wrap. The full-buffer case is covered by the overflow test and by the assertions on the count. The long gapped runs bring the two enables together many times at random phases, and are judged by the balance between pushes, pops and `fill`.

// File: rtl/rmnco_pkg.sv
// Shared types for the rate-matching NCO.
// Assumes nothing beyond a single clock domain.
package rmnco_pkg;
    // Occupancy flags that the FIFO derives from its pointers.
    typedef struct packed {
        logic full;
        logic empty;
    } fifo_stat_t;
endpackage

// File: rtl/rmnco_fifo.sv
// Synchronous FIFO with a combinational occupancy count.
// Assumes a power-of-two depth. The read data is the head word, shown
// combinationally. A push while full is accepted only if a pop frees a slot
// in the same cycle.
module rmnco_fifo
    import rmnco_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W:0]   count,
    output fifo_stat_t        stat,
    output logic              ovf,
    output logic              unf
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0]  wr_q, rd_q;
    logic              do_push, do_pop;

    // Occupancy and flags come from the pointer difference.
    always_comb begin
        count      = wr_q - rd_q;
        stat.empty = (count == '0);
        stat.full  = (count == CNT_W'(DEPTH));
        do_pop     = pop && !stat.empty;
        do_push    = push && (!stat.full || do_pop);
        rdata      = mem[rd_q[ADDR_W-1:0]];
    end

    // Storage write; no reset is needed for the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q[ADDR_W-1:0]] <= wdata;
    end

    // Pointer advance and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            if (push && !do_push) ovf <= 1'b1;
            if (pop && stat.empty) unf <= 1'b1;
        end
    end

    // R5: a dropped push keeps the count and raises the flag
    a_r5_drop_full: assert property (@(posedge clk) disable iff (!rst_n)
        (push && stat.full && !pop) |=> (ovf && count == $past(count)));
    // R5: overflow is sticky
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);
    // R6: a push together with a valid pop leaves occupancy unchanged
    a_r6_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !stat.empty) |=> (count == $past(count)));
    // R4: occupancy never goes past the depth
    a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
endmodule

// File: rtl/rmnco_phase_acc.sv
// Modulo phase accumulator whose increment is the FIFO occupancy.
// Assumes the increment never exceeds DEPTH. The modulus is kept above
// DEPTH, so one subtraction always brings the sum back into range.
// The wrap output is registered.
module rmnco_phase_acc #(
    parameter int ACC_W = 12,
    parameter int CNT_W = 5,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] cfg_modulus,
    input  logic [CNT_W-1:0] incr,
    output logic             wrap
);
    localparam logic [ACC_W-1:0] MOD_MAX = '1;
    localparam logic [ACC_W-1:0] MOD_MIN = ACC_W'(DEPTH + 1);

    logic [ACC_W-1:0] mod_q, acc_q, eff_mod;
    logic [ACC_W:0]   sum;

    // Map the configured modulus to a legal value.
    always_comb begin
        if (cfg_modulus == '0)          eff_mod = MOD_MAX;
        else if (cfg_modulus < MOD_MIN) eff_mod = MOD_MIN;
        else                            eff_mod = cfg_modulus;
        sum = {1'b0, acc_q} + (ACC_W + 1)'(incr);
    end

    // Load the modulus in reset; otherwise accumulate and wrap by subtraction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mod_q <= eff_mod;
            acc_q <= '0;
            wrap  <= 1'b0;
        end else if (sum >= {1'b0, mod_q}) begin
            acc_q <= ACC_W'(sum - {1'b0, mod_q});
            wrap  <= 1'b1;
        end else begin
            acc_q <= ACC_W'(sum);
            wrap  <= 1'b0;
        end
    end

    // R2: the residue always stays below the modulus
    a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < mod_q);
    // R3: the captured modulus is never below its floor
    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        mod_q >= MOD_MIN);
    // R7: a zero increment holds the phase and gives no wrap
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (incr == '0) |=> (acc_q == $past(acc_q) && !wrap));
endmodule

// File: rtl/fill_rate_nco.sv
// Rate-matching NCO: a gapped write enable fills a FIFO, and a phase
// accumulator stepped by the fill level issues the read enable.
// Assumes one clock domain and an ACC_W wide enough to hold DEPTH+1.
module fill_rate_nco
    import rmnco_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4,
    parameter int ACC_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  cfg_modulus,
    input  logic              in_en,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_en,
    output logic [DATA_W-1:0] out_data,
    output logic [ADDR_W:0]   fill,
    output logic              overflow,
    output logic              underflow
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int CNT_W = ADDR_W + 1;

    fifo_stat_t stat;
    logic       wrap;

    rmnco_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (in_en),
        .pop   (wrap),
        .wdata (in_data),
        .rdata (out_data),
        .count (fill),
        .stat  (stat),
        .ovf   (overflow),
        .unf   (underflow)
    );

    rmnco_phase_acc #(.ACC_W(ACC_W), .CNT_W(CNT_W), .DEPTH(DEPTH)) u_acc (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_modulus (cfg_modulus),
        .incr        (fill),
        .wrap        (wrap)
    );

    // Output enable is the registered wrap pulse.
    assign out_en = wrap;

    // R7: no stored word means no wrap in the next cycle
    a_r7_no_pulse_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |=> !out_en);
    // R8: a read enable always finds data
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_en |-> !stat.empty);
    // R8: the underflow flag stays clear
    a_r8_flag_low: assert property (@(posedge clk) disable iff (!rst_n)
        !underflow);
endmodule

// File: tb/fill_rate_nco_bench.sv
`timescale 1ns/1ps
module fill_rate_nco_bench;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;
    localparam int ACC_W  = 12;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ACC_W-1:0]  cfg_modulus = '0;
    logic              in_en = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_en;
    logic [DATA_W-1:0] out_data;
    logic [ADDR_W:0]   fill;
    logic              overflow, underflow;

    int checks = 0;
    int errors = 0;
    int pops = 0;
    int pushes = 0;

    fill_rate_nco #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .ACC_W(ACC_W)) u_fill_rate_nco (
        .clk(clk), .rst_n(rst_n), .cfg_modulus(cfg_modulus),
        .in_en(in_en), .in_data(in_data), .out_en(out_en),
        .out_data(out_data), .fill(fill), .overflow(overflow),
        .underflow(underflow)
    );

    always #4 clk = ~clk;

    // Count valid pops at the falling edge, where outputs are settled.
    always @(negedge clk) if (rst_n && out_en && fill != 0) pops++;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int m);
        @(negedge clk);
        rst_n = 1'b0;
        in_en = 1'b0;
        cfg_modulus = ACC_W'(m);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pops = 0;
        pushes = 0;
    endtask

    task automatic push_word(input logic [DATA_W-1:0] d);
        @(negedge clk);
        in_en = 1'b1;
        in_data = d;
        @(negedge clk);
        in_en = 1'b0;
    endtask

    // Count falling edges until out_en is seen.
    task automatic wait_out(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!out_en && n < limit);
    endtask

    task automatic t_reset;
        do_reset(100);
        @(negedge clk);
        check(out_en == 0 && fill == 0 && !overflow && !underflow, "R1 reset state",
              {out_en, fill, overflow, underflow}, 0);
    endtask

    // One word, exact wrap time, head data, single-cycle pulse, then idle.
    task automatic t_first_wrap(input int cfg, input int exp_m, input logic [7:0] d);
        int n;
        do_reset(cfg);
        push_word(d);
        wait_out(n, exp_m + 50);
        check(n == exp_m, $sformatf("R2/R3 wrap time cfg=%0d", cfg), n, exp_m);
        check(out_data == d, "R4 head word", out_data, d);
        @(negedge clk);
        check(!out_en && fill == 0, "R2 single pulse and pop", {out_en, fill}, 0);
        repeat (200) begin
            @(negedge clk);
            if (out_en) break;
        end
        check(!out_en, "R7 empty holds", out_en, 0);
    endtask

    task automatic t_same_cycle;
        int n;
        do_reset(17);
        push_word(8'hA1);
        wait_out(n, 100);
        check(out_en && fill == 1, "R6 pre state", fill, 1);
        in_en = 1'b1;
        in_data = 8'hB2;
        @(negedge clk);
        in_en = 1'b0;
        check(fill == 1, "R6 push with pop keeps fill", fill, 1);
        wait_out(n, 100);
        check(out_en && out_data == 8'hB2, "R6 new word readout", out_data, 8'hB2);
    endtask

    task automatic t_overflow_order;
        int n;
        do_reset(4000);
        for (int i = 0; i < DEPTH + 1; i++) begin
            @(negedge clk);
            in_en = 1'b1;
            in_data = 8'(8'h40 + i);
        end
        @(negedge clk);
        in_en = 1'b0;
        check(fill == DEPTH, "R5 fill at depth", fill, DEPTH);
        check(overflow == 1'b1, "R5 overflow set", overflow, 1);
        for (int i = 0; i < DEPTH; i++) begin
            wait_out(n, 5000);
            check(out_en && out_data == 8'(8'h40 + i), "R4 order", out_data, 8'h40 + i);
        end
        @(negedge clk);
        check(fill == 0 && overflow, "R5 flag sticky after drain", {fill, overflow}, 1);
        check(!underflow, "R8 no underflow", underflow, 0);
    endtask

    // Gapped input with period 16 and k pushes per period, run for cyc cycles.
    task automatic run_gapped(input int mul, input int k, input int cyc);
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            in_en = ((i * mul) % 16) < k;
            in_data = 8'(i);
            if (in_en) pushes++;
        end
        @(negedge clk);
        in_en = 1'b0;
    endtask

    task automatic t_rate;
        do_reset(64);
        run_gapped(7, 3, 6000);
        check(!overflow, "R9 no drop fast", overflow, 0);
        check(pushes - pops == int'(fill), "R9 balance fast", pushes - pops, fill);
        check(fill >= 9 && fill <= 15, "R9 settled fill fast", fill, 12);
        run_gapped(5, 1, 6000);
        check(pushes - pops == int'(fill), "R9 balance slow", pushes - pops, fill);
        check(fill >= 2 && fill <= 6, "R9 settled fill slow", fill, 4);
        check(!underflow, "R8 no underflow gapped", underflow, 0);
    endtask

    initial begin
        #(8ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_first_wrap(100, 100, 8'h5A);
        t_first_wrap(17, 17, 8'h11);
        t_first_wrap(5, 17, 8'h22);
        t_first_wrap(0, 4095, 8'h33);
        t_same_cycle();
        t_overflow_order();
        t_rate();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule